// File: doc/BRIEF.md
# DMA Remapping Unit Control Register File

This block is the software-visible register file of a DMA address-remapping unit. It presents fixed identification and capability words, a root-table address register, and three command paths: a global command word that controls translation on/off, root-pointer latching and write-buffer flushing, a context-cache invalidate command, and a translation-cache (IOTLB) invalidate command. The IOTLB command sits at an offset that the extended capability value defines.

Every command is a one-shot request. When software writes a command, the block sends a one-cycle strobe to the downstream translation engine. It then marks the command as pending. The command completes after a per-command latency, counted in clocks, and only once the engine has returned its done acknowledgement. Completion shows differently for each command. Translation enable and root-pointer latching set status bits. The flush status bit drops. The two invalidate commands clear their own start bit. Software polls these bits to learn that a command has finished.

The bus is a simple 32-bit word port with byte addresses. A 64-bit register appears as two words, with the low word at the base offset and the high word at base + 4. Read data is registered and is valid one cycle after the read strobe.

Top module: `rmu_regs`

## Requirements
- R1: After reset the identification word (0x00), capability words (0x08/0x0C) and extended capability words (0x10/0x14) read their elaboration values. The status word (0x1C) reads 0, `xlt_en` is 0 and `op_req` is 0.
- R2: Writes to 0x00, 0x08, 0x0C, 0x10, 0x14 and 0x1C are ignored, and later reads return the values those registers held before the write.
- R3: In the command word at 0x18, bit 31 requests translation on or off. A write whose bit 31 differs from the current state pulses `op_req[0]` in the next cycle. If the engine acknowledges, `xlt_en` and status bit 31 take the new value exactly LAT_TE+1 clock edges after the write edge.
- R4: A pending command does not complete until its bit of `op_done` has been seen high while the command is pending. Without that acknowledgement its status stays unchanged indefinitely.
- R5: Command bit 30 copies the root-table address (0x20 low, 0x24 high) to `rt_ptr` at the write edge, pulses `op_req[1]` and clears status bit 30. Status bit 30 is set on completion. Later writes to the root-table address do not alter `rt_ptr` until the next such command.
- R6: Command bit 27 pulses `op_req[2]`. Status bit 27 reads 1 while the flush is pending and 0 once it completes.
- R7: A write to 0x2C with bit 31 set and a non-zero granularity in bits 30:29 pulses `op_req[3]` and drives that granularity on `cc_gran`. Bit 31 reads 1 until completion and then clears itself, while the granularity keeps reading back.
- R8: The IOTLB register sits at ECAP[17:8]*16+8, with its high word at +12. In the high word, bit 31 starts the invalidation, bits 29:28 give the granularity (1 global, 2 domain, 3 page), bits 17 and 16 request draining of reads and writes, and bits 15:0 hold the domain id. An accepted write pulses `op_req[4]` with the fields on `tlb_gran`, `tlb_drain` and `tlb_dom`. Bit 31 clears itself on completion.
- R9: An invalidate start with granularity 0 is ignored: no request is sent and bit 31 reads 0.
- R10: A domain or page IOTLB invalidate whose domain id is not below the domain count is ignored. The count comes from CAP[2:0], where codes 0..6 mean 16, 64, 256, 1K, 4K, 16K and 64K.
- R11: A write to a command that is still pending is ignored. No second request is sent and the stored fields are unchanged.
- R12: The command word at 0x18 reads as 0.
- R13: Each `op_req` bit is a single-cycle pulse. The index order is 0 translation, 1 root pointer, 2 flush, 3 context invalidate, 4 IOTLB invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| op_req | output | 5 | One-cycle command strobes to the engine |
| op_done | input | 5 | Done acknowledgements from the engine |
| xlt_en | output | 1 | Translation currently enabled |
| rt_ptr | output | 64 | Root-table address latched by the last root-pointer command |
| cc_gran | output | 2 | Granularity of the last accepted context invalidate |
| tlb_gran | output | 2 | Granularity of the last accepted IOTLB invalidate |
| tlb_drain | output | 2 | Drain reads (bit 1) and writes (bit 0) of the last IOTLB invalidate |
| tlb_dom | output | 16 | Domain id of the last IOTLB invalidate |

## Verification
On every cycle, the assertions check a fixed set of properties. Every strobe lasts one cycle. The root pointer changes only alongside its strobe. An invalidate never leaves with granularity 0. An IOTLB invalidate never carries a domain id that the capability-defined domain count forbids. The remaining properties depend on sequences and can only be shown by the directed scenarios: the exact completion latency, the wait for a missing acknowledgement, the separate completion polarity of each command, rejected writes while a command is pending, and read-only registers that keep their values after writes.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    localparam int unsigned NUM_OPS = 5;
    localparam int unsigned CNT_W   = 16;

    typedef enum int unsigned {
        OP_TE  = 0,
        OP_RTP = 1,
        OP_WBF = 2,
        OP_CC  = 3,
        OP_TLB = 4
    } op_idx_e;

    // byte offsets of the fixed part of the map
    localparam int unsigned OFF_VER     = 'h00;
    localparam int unsigned OFF_CAP_LO  = 'h08;
    localparam int unsigned OFF_CAP_HI  = 'h0C;
    localparam int unsigned OFF_ECAP_LO = 'h10;
    localparam int unsigned OFF_ECAP_HI = 'h14;
    localparam int unsigned OFF_GCMD    = 'h18;
    localparam int unsigned OFF_GSTS    = 'h1C;
    localparam int unsigned OFF_RTA_LO  = 'h20;
    localparam int unsigned OFF_RTA_HI  = 'h24;
    localparam int unsigned OFF_CC_LO   = 'h28;
    localparam int unsigned OFF_CC_HI   = 'h2C;

    // bit positions inside the command and status words
    localparam int unsigned GB_TE  = 31;
    localparam int unsigned GB_RTP = 30;
    localparam int unsigned GB_WBF = 27;

    localparam logic [1:0] TLB_GLOBAL = 2'd1;

    typedef struct packed {
        logic       go;
        logic [1:0] gran;
    } cc_cmd_t;

    typedef struct packed {
        logic       go;
        logic [1:0] gran;
        logic [1:0] drain;
        logic [15:0] dom;
    } tlb_cmd_t;

    function automatic cc_cmd_t cc_unpack(input logic [31:0] w);
        cc_cmd_t c;
        c.go   = w[31];
        c.gran = w[30:29];
        return c;
    endfunction

    function automatic tlb_cmd_t tlb_unpack(input logic [31:0] w);
        tlb_cmd_t t;
        t.go    = w[31];
        t.gran  = w[29:28];
        t.drain = w[17:16];
        t.dom   = w[15:0];
        return t;
    endfunction

    function automatic logic [31:0] tlb_pack(input logic busy, input logic [1:0] gran,
                                             input logic [1:0] drain, input logic [15:0] dom);
        return {busy, 1'b0, gran, 10'd0, drain, dom};
    endfunction

    function automatic logic [31:0] sts_pack(input logic te, input logic rtp, input logic wbf);
        logic [31:0] s;
        s         = '0;
        s[GB_TE]  = te;
        s[GB_RTP] = rtp;
        s[GB_WBF] = wbf;
        return s;
    endfunction

    // domain-count code to number of domains; code 7 allows none
    function automatic int unsigned dom_count(input logic [2:0] code);
        if (code > 3'd6) return 0;
        return 32'd16 << (2 * int'(code));
    endfunction

endpackage

// File: rtl/rmu_op_tracker.sv
module rmu_op_tracker
    import rmu_pkg::*;
#(
    parameter int unsigned LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ack,
    output logic busy,
    output logic finish
);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(LAT);

    logic [CNT_W-1:0] cnt;
    logic             ack_seen;

    assign finish = busy && (cnt == '0) && (ack_seen || ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            ack_seen <= 1'b0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            cnt      <= LAT_C;
            ack_seen <= 1'b0;
        end else if (finish) begin
            busy     <= 1'b0;
            ack_seen <= 1'b0;
        end else if (busy) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (ack) ack_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/rmu_read_mux.sv
module rmu_read_mux
    import rmu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter logic [31:0] VER_VAL  = 32'h10,
    parameter logic [63:0] CAP_VAL  = 64'h0,
    parameter logic [63:0] ECAP_VAL = 64'h0,
    parameter int unsigned TLB_LO_A = 'h108
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               xlt_en,
    input  logic               rtps,
    input  logic [NUM_OPS-1:0] busy,
    input  logic [63:0]        rta,
    input  logic [1:0]         cc_gran,
    input  logic [1:0]         tlb_gran,
    input  logic [1:0]         tlb_drain,
    input  logic [15:0]        tlb_dom,
    output logic [31:0]        data
);
    localparam int unsigned TLB_HI_A = TLB_LO_A + 4;

    always_comb begin
        data = '0;
        case (int'(addr))
            OFF_VER:     data = VER_VAL;
            OFF_CAP_LO:  data = CAP_VAL[31:0];
            OFF_CAP_HI:  data = CAP_VAL[63:32];
            OFF_ECAP_LO: data = ECAP_VAL[31:0];
            OFF_ECAP_HI: data = ECAP_VAL[63:32];
            OFF_GSTS:    data = sts_pack(xlt_en, rtps, busy[OP_WBF]);
            OFF_RTA_LO:  data = rta[31:0];
            OFF_RTA_HI:  data = rta[63:32];
            OFF_CC_HI:   data = {busy[OP_CC], cc_gran, 29'd0};
            TLB_HI_A:    data = tlb_pack(busy[OP_TLB], tlb_gran, tlb_drain, tlb_dom);
            default:     data = '0;
        endcase
    end
endmodule

// File: rtl/rmu_regs.sv
module rmu_regs
    import rmu_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter logic [31:0] VER_VAL  = 32'h0000_0010,
    parameter logic [63:0] CAP_VAL  = 64'h0000_000C_0000_0412,
    parameter logic [63:0] ECAP_VAL = 64'h0000_0000_0000_1001,
    parameter int unsigned LAT_TE   = 4,
    parameter int unsigned LAT_RTP  = 3,
    parameter int unsigned LAT_WBF  = 5,
    parameter int unsigned LAT_CC   = 6,
    parameter int unsigned LAT_TLB  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [4:0]         op_req,
    input  logic [4:0]         op_done,
    output logic               xlt_en,
    output logic [63:0]        rt_ptr,
    output logic [1:0]         cc_gran,
    output logic [1:0]         tlb_gran,
    output logic [1:0]         tlb_drain,
    output logic [15:0]        tlb_dom
);
    localparam int unsigned IRO      = int'(ECAP_VAL[17:8]);
    localparam int unsigned TLB_LO_A = IRO * 16 + 8;
    localparam int unsigned TLB_HI_A = TLB_LO_A + 4;
    localparam int unsigned DOM_CNT  = dom_count(CAP_VAL[2:0]);
    localparam int unsigned LAT_TAB [NUM_OPS] = '{LAT_TE, LAT_RTP, LAT_WBF, LAT_CC, LAT_TLB};

    logic [NUM_OPS-1:0] start, busy, finish;
    logic               rtps;
    logic [63:0]        rta;
    logic               wr_gcmd, wr_rta_lo, wr_rta_hi, wr_cc, wr_tlb;
    cc_cmd_t            cc_in;
    tlb_cmd_t           tlb_in;
    logic               tlb_dom_ok;
    logic [31:0]        rd_mux;
    logic               unused_bits;

    assign unused_bits = ^{bus_addr[1:0]};

    assign wr_gcmd   = bus_wr && (int'(bus_addr) == OFF_GCMD);
    assign wr_rta_lo = bus_wr && (int'(bus_addr) == OFF_RTA_LO);
    assign wr_rta_hi = bus_wr && (int'(bus_addr) == OFF_RTA_HI);
    assign wr_cc     = bus_wr && (int'(bus_addr) == OFF_CC_HI);
    assign wr_tlb    = bus_wr && (int'(bus_addr) == TLB_HI_A);

    assign cc_in      = cc_unpack(bus_wdata);
    assign tlb_in     = tlb_unpack(bus_wdata);
    assign tlb_dom_ok = (tlb_in.gran == TLB_GLOBAL) || (32'(tlb_in.dom) < DOM_CNT);

    // request acceptance: each path only while idle
    always_comb begin
        start         = '0;
        start[OP_TE]  = wr_gcmd && !busy[OP_TE] && (bus_wdata[GB_TE] != xlt_en);
        start[OP_RTP] = wr_gcmd && !busy[OP_RTP] && bus_wdata[GB_RTP];
        start[OP_WBF] = wr_gcmd && !busy[OP_WBF] && bus_wdata[GB_WBF];
        start[OP_CC]  = wr_cc && !busy[OP_CC] && cc_in.go && (cc_in.gran != 2'd0);
        start[OP_TLB] = wr_tlb && !busy[OP_TLB] && tlb_in.go && (tlb_in.gran != 2'd0)
                        && tlb_dom_ok;
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_trk
        rmu_op_tracker #(.LAT(LAT_TAB[g])) u_trk (
            .clk    (clk),
            .rst    (rst),
            .start  (start[g]),
            .ack    (op_done[g]),
            .busy   (busy[g]),
            .finish (finish[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_req    <= '0;
            xlt_en    <= 1'b0;
            rtps      <= 1'b0;
            rta       <= '0;
            rt_ptr    <= '0;
            cc_gran   <= '0;
            tlb_gran  <= '0;
            tlb_drain <= '0;
            tlb_dom   <= '0;
        end else begin
            op_req <= start;
            if (wr_rta_lo) rta[31:0]  <= bus_wdata;
            if (wr_rta_hi) rta[63:32] <= bus_wdata;
            if (finish[OP_TE]) xlt_en <= ~xlt_en;
            if (start[OP_RTP]) begin
                rt_ptr <= rta;
                rtps   <= 1'b0;
            end else if (finish[OP_RTP]) begin
                rtps   <= 1'b1;
            end
            if (start[OP_CC]) cc_gran <= cc_in.gran;
            if (start[OP_TLB]) begin
                tlb_gran  <= tlb_in.gran;
                tlb_drain <= tlb_in.drain;
                tlb_dom   <= tlb_in.dom;
            end
        end
    end

    rmu_read_mux #(
        .ADDR_W   (ADDR_W),
        .VER_VAL  (VER_VAL),
        .CAP_VAL  (CAP_VAL),
        .ECAP_VAL (ECAP_VAL),
        .TLB_LO_A (TLB_LO_A)
    ) u_rd (
        .addr      (bus_addr),
        .xlt_en    (xlt_en),
        .rtps      (rtps),
        .busy      (busy),
        .rta       (rta),
        .cc_gran   (cc_gran),
        .tlb_gran  (tlb_gran),
        .tlb_drain (tlb_drain),
        .tlb_dom   (tlb_dom),
        .data      (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/rmu_regs_chk.sv
module rmu_regs_chk
    import rmu_pkg::*;
#(
    parameter logic [63:0] CAP_VAL = 64'h0
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  op_req,
    input logic [63:0] rt_ptr,
    input logic [1:0]  cc_gran,
    input logic [1:0]  tlb_gran,
    input logic [15:0] tlb_dom
);
    localparam int unsigned DOM_CNT = dom_count(CAP_VAL[2:0]);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (op_req != '0) |=> ((op_req & $past(op_req)) == '0)); // R13

    AST_RTPTR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        !op_req[OP_RTP] |-> $stable(rt_ptr)); // R5

    AST_CC_GRAN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        op_req[OP_CC] |-> (cc_gran != 2'd0)); // R9

    AST_TLB_GRAN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        op_req[OP_TLB] |-> (tlb_gran != 2'd0)); // R9

    AST_TLB_DOM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op_req[OP_TLB] && (tlb_gran != TLB_GLOBAL)) |-> (32'(tlb_dom) < DOM_CNT)); // R10
endmodule

bind rmu_regs rmu_regs_chk #(.CAP_VAL(CAP_VAL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_req   (op_req),
    .rt_ptr   (rt_ptr),
    .cc_gran  (cc_gran),
    .tlb_gran (tlb_gran),
    .tlb_dom  (tlb_dom)
);

// File: tb/sim_rmu_regs.sv
module sim_rmu_regs;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam logic [31:0] VER  = 32'h0000_0010;
    localparam logic [63:0] CAP  = 64'h0000_000C_0000_0412;
    localparam logic [63:0] ECAP = 64'h0000_0000_0000_1001;
    localparam int L_TE = 4, L_RTP = 3, L_WBF = 5, L_CC = 6, L_TLB = 8;
    localparam int TLB_HI = 'h10 * 16 + 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [4:0] op_req, op_done, ack_en = 5'b11111, ack_q, ack_man = '0;
    logic xlt_en;
    logic [63:0] rt_ptr;
    logic [1:0] cc_gran, tlb_gran, tlb_drain;
    logic [15:0] tlb_dom;

    int checks = 0, fails = 0;
    int pulses [5] = '{0, 0, 0, 0, 0};
    int wide = 0;
    logic [4:0] req_prev = '0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // engine model: acknowledge one cycle after each strobe when enabled
    always @(posedge clk) begin
        ack_q <= rst ? 5'b0 : (op_req & ack_en);
        if (!rst) begin
            for (int i = 0; i < 5; i++) if (op_req[i]) pulses[i]++;
            if ((op_req & req_prev) != '0) wide++;
        end
        req_prev <= op_req;
    end
    assign op_done = ack_q | ack_man;

    rmu_regs #(
        .ADDR_W(AW), .VER_VAL(VER), .CAP_VAL(CAP), .ECAP_VAL(ECAP),
        .LAT_TE(L_TE), .LAT_RTP(L_RTP), .LAT_WBF(L_WBF), .LAT_CC(L_CC), .LAT_TLB(L_TLB)
    ) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .op_req(op_req), .op_done(op_done),
        .xlt_en(xlt_en), .rt_ptr(rt_ptr), .cc_gran(cc_gran), .tlb_gran(tlb_gran),
        .tlb_drain(tlb_drain), .tlb_dom(tlb_dom)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd('h00, d); chk("R1 version", d, VER);
        rd('h08, d); chk("R1 cap lo", d, CAP[31:0]);
        rd('h0C, d); chk("R1 cap hi", d, CAP[63:32]);
        rd('h10, d); chk("R1 ecap lo", d, ECAP[31:0]);
        rd('h1C, d); chk("R1 status", d, 0);
        chk("R1 xlt_en", xlt_en, 0);
        chk("R1 op_req", op_req, 0);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr('h00, 32'hFFFF_FFFF); wr('h0C, 32'h1234_5678);
        wr('h14, 32'hFFFF_FFFF); wr('h1C, 32'hFFFF_FFFF);
        rd('h00, d); chk("R2 version kept", d, VER);
        rd('h0C, d); chk("R2 cap hi kept", d, CAP[63:32]);
        rd('h14, d); chk("R2 ecap hi kept", d, ECAP[63:32]);
        rd('h1C, d); chk("R2 status kept", d, 0);
        chk("R2 no request", pulses[0] + pulses[1] + pulses[2], 0);
    endtask

    task automatic t_te_on;
        logic [31:0] d;
        wr('h18, 32'h8000_0000);
        chk("R3 te strobe", op_req[0], 1);
        repeat (L_TE) @(negedge clk);
        chk("R3 xlt_en before latency", xlt_en, 0);
        @(negedge clk);
        chk("R3 xlt_en at latency", xlt_en, 1);
        rd('h1C, d); chk("R3 status te", d[31], 1);
        rd('h18, d); chk("R12 command reads zero", d, 0);
    endtask

    task automatic t_ack_hold;
        logic [31:0] d;
        ack_en[0] = 1'b0;
        wr('h18, 32'h0000_0000);
        idle(20);
        chk("R4 xlt_en held without ack", xlt_en, 1);
        rd('h1C, d); chk("R4 status held", d[31], 1);
        @(negedge clk); ack_man[0] = 1'b1;
        @(negedge clk); ack_man[0] = 1'b0;
        chk("R4 xlt_en off after ack", xlt_en, 0);
        rd('h1C, d); chk("R3 status te off", d[31], 0);
        ack_en[0] = 1'b1;
    endtask

    task automatic t_srtp;
        logic [31:0] d;
        wr('h20, 32'h1234_5000); wr('h24, 32'h0000_0001);
        wr('h18, 32'h4000_0000);
        chk("R5 rtp strobe", op_req[1], 1);
        chk("R5 rt_ptr latched", rt_ptr, 64'h0000_0001_1234_5000);
        rd('h1C, d); chk("R5 status pending", d[30], 0);
        wr('h20, 32'hAAAA_0000);
        idle(L_RTP + 2);
        rd('h1C, d); chk("R5 status set", d[30], 1);
        chk("R5 rt_ptr unchanged", rt_ptr, 64'h0000_0001_1234_5000);
        rd('h20, d); chk("R5 address readback", d, 32'hAAAA_0000);
        chk("R3 te untouched", xlt_en, 0);
    endtask

    task automatic t_wbf;
        logic [31:0] d;
        wr('h18, 32'h0800_0000);
        chk("R6 flush strobe", op_req[2], 1);
        rd('h1C, d); chk("R6 flush busy", d[27], 1);
        idle(L_WBF + 2);
        rd('h1C, d); chk("R6 flush done", d[27], 0);
    endtask

    task automatic t_cc;
        logic [31:0] d;
        int p0 = pulses[3];
        wr('h2C, 32'hA000_0000);
        chk("R7 cc strobe", op_req[3], 1);
        chk("R7 cc gran", cc_gran, 2'd1);
        rd('h2C, d); chk("R7 cc pending", d, 32'hA000_0000);
        wr('h2C, 32'hC000_0000);
        chk("R11 cc ignored while pending", pulses[3], p0 + 1);
        idle(L_CC + 2);
        rd('h2C, d); chk("R7 cc self clear", d, 32'h2000_0000);
        chk("R11 cc gran unchanged", cc_gran, 2'd1);
    endtask

    task automatic t_tlb;
        logic [31:0] d;
        int p0 = pulses[4];
        wr(TLB_HI, 32'hA003_0042);
        chk("R8 tlb strobe", op_req[4], 1);
        chk("R8 tlb fields", {tlb_gran, tlb_drain, tlb_dom}, {2'd2, 2'd3, 16'h0042});
        rd(TLB_HI, d); chk("R8 tlb pending", d, 32'hA003_0042);
        wr(TLB_HI, 32'h9000_0007);
        chk("R11 tlb ignored while pending", pulses[4], p0 + 1);
        idle(L_TLB + 2);
        rd(TLB_HI, d); chk("R8 tlb self clear", d, 32'h2003_0042);
        chk("R11 tlb dom unchanged", tlb_dom, 16'h0042);
    endtask

    task automatic t_reserved;
        logic [31:0] d;
        int c0 = pulses[3], t0 = pulses[4];
        wr('h2C, 32'h8000_0000);
        wr(TLB_HI, 32'h8000_0001);
        idle(2);
        chk("R9 cc gran0 no request", pulses[3], c0);
        chk("R9 tlb gran0 no request", pulses[4], t0);
        rd('h2C, d); chk("R9 cc bit clear", d[31], 0);
        rd(TLB_HI, d); chk("R9 tlb bit clear", d[31], 0);
    endtask

    task automatic t_domain;
        logic [31:0] d;
        int t0 = pulses[4];
        wr(TLB_HI, 32'hA000_0100);
        idle(2);
        chk("R10 dom 256 rejected", pulses[4], t0);
        rd(TLB_HI, d); chk("R10 bit clear", d[31], 0);
        wr(TLB_HI, 32'hB000_00FF);
        chk("R10 dom 255 page accepted", op_req[4], 1);
        chk("R10 dom field", tlb_dom, 16'h00FF);
        idle(L_TLB + 2);
        wr(TLB_HI, 32'h9000_FFFF);
        chk("R10 global any dom", op_req[4], 1);
        idle(L_TLB + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readonly();
        t_te_on();
        t_ack_hold();
        t_srtp();
        t_wbf();
        t_cc();
        t_tlb();
        t_reserved();
        t_domain();
        chk("R13 strobes single cycle", wide, 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule